// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This unit sits between a 32-bit core and a word-wide data memory. Each request carries an operation code, a base register value, a 16-bit signed byte offset and, for stores, the register data. The unit adds the base to the sign-extended offset to form a byte address. It then drives a word-aligned memory address, per-lane write enables and store data copied into every lane. A request with base zero gives direct addressing, and a request with offset zero gives register-indirect addressing. Both forms use the same adder.

Loads return one word from memory. The unit picks out the addressed byte or halfword, using big-endian lane order, and widens it to 32 bits with sign or zero fill. The load-upper-immediate operation uses the same response path and makes no memory access. A word access that is not word-aligned, or a halfword access at an odd byte address, raises a misalignment flag. Such an access produces no memory read, no write enable and no response.

The unit is pipelined. Memory-side outputs appear one cycle after a request. Memory must return read data combinationally from `mem_addr` within that cycle. The response appears one cycle after that.

Top module: `lsu_lane_align`

## Requirements
- R1: The effective address is `req_base` plus `req_offset` sign-extended to 32 bits, in bytes, wrapping modulo 2^32. On the clock edge that samples a valid memory request, `mem_addr` takes this address with bits 1:0 forced to zero.
- R2: Lane order is big-endian, and `mem_we[i]` enables `mem_wdata[8i+7:8i]`. A byte store at byte offset k (address bits 1:0) asserts only `mem_we[3-k]`. A halfword store asserts 4'b1100 at offset 0 and 4'b0011 at offset 2. A word store asserts 4'b1111.
- R3: A byte store copies `req_wdata[7:0]` into all four lanes of `mem_wdata`. A halfword store copies `req_wdata[15:0]` into both halves. A word store passes `req_wdata` through unchanged.
- R4: Signed byte and signed halfword loads sign-extend the selected field of `mem_rdata` to 32 bits. A byte at offset k is `mem_rdata[31-8k:24-8k]`. The halfword at offset 0 is `mem_rdata[31:16]`, and the one at offset 2 is `mem_rdata[15:0]`.
- R5: Unsigned byte and unsigned halfword loads use the same field selection as R4 but fill the upper bits with zeros.
- R6: A word load returns `mem_rdata` unchanged. Every load response appears on `rsp_data` with `rsp_valid` high one cycle after `mem_rd` is high, and `rsp_data` is taken from `mem_rdata` as sampled on that edge.
- R7: An access is misaligned when it is a word access with address bits 1:0 not 00, or a halfword access with address bit 0 set. One cycle after the request, `misalign` is high, `mem_we` is 0 and `mem_rd` is 0, and the access never produces a response.
- R8: An aligned load raises `mem_rd` for exactly one cycle with `mem_we` at zero. An idle cycle or an unused operation code leaves `mem_rd`, `mem_we`, `misalign` and `rsp_valid` low.
- R9: Load-upper-immediate gives `rsp_data` = {`req_offset`, 16'h0000} with `rsp_valid` high, two cycles after the request. It makes no memory read or write.
- R10: While `rst_n` is low, `mem_addr`, `mem_we`, `mem_wdata`, `mem_rd`, `misalign`, `rsp_valid` and `rsp_data` are all zero.

Operation codes on `req_op`: 0 signed byte load, 1 signed halfword load, 2 word load, 3 unsigned byte load, 4 unsigned halfword load, 5 byte store, 6 halfword store, 7 word store, 8 load-upper-immediate, 9 to 15 unused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 4 | Operation code |
| req_base | input | 32 | Base register value |
| req_offset | input | 16 | Signed byte offset, or the immediate for load-upper-immediate |
| req_wdata | input | 32 | Store source register |
| mem_rdata | input | 32 | Word returned by memory for `mem_addr` |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_we | output | 4 | Per-lane write enables |
| mem_wdata | output | 32 | Lane-replicated store data |
| misalign | output | 1 | Misaligned access flag |
| rsp_valid | output | 1 | Load or load-upper-immediate result valid |
| rsp_data | output | 32 | Extended load result |

## Verification
A wrong lane decode shows up one cycle after the store, as a write-enable pattern that differs from the expected one. It also corrupts the bench memory, so a later load of that word returns a wrong value. Held state that goes wrong between the stages shows up on the response one cycle after `mem_rd`. This covers a lost address offset, a lost operation code or a lost load-upper-immediate flag, each of which gives a wrong extraction or a wrong extension. A misalignment decode error shows up after one cycle as a stray write enable, a stray read strobe or a missing flag. The reference model is compared with the outputs on every cycle, so each of these faults is reported in the cycle where it first reaches a port.

// File: rtl/lsu_lane_align.sv
module lsu_lane_align (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [3:0]  req_op,
  input  logic [31:0] req_base,
  input  logic [15:0] req_offset,
  input  logic [31:0] req_wdata,
  input  logic [31:0] mem_rdata,
  output logic [31:0] mem_addr,
  output logic        mem_rd,
  output logic [3:0]  mem_we,
  output logic [31:0] mem_wdata,
  output logic        misalign,
  output logic        rsp_valid,
  output logic [31:0] rsp_data
);
  localparam logic [3:0] OP_LB = 4'd0, OP_LH = 4'd1, OP_LW = 4'd2, OP_LBU = 4'd3,
                         OP_LHU = 4'd4, OP_SB = 4'd5, OP_SH = 4'd6, OP_SW = 4'd7,
                         OP_LUI = 4'd8;

  logic [31:0] ea;
  logic is_load, is_store, is_lui, sz_byte, sz_half, sz_word, bad_align;
  logic [3:0]  lanes;
  logic [31:0] wrep;

  assign ea       = req_base + {{16{req_offset[15]}}, req_offset};
  assign is_load  = req_valid && (req_op <= OP_LHU);
  assign is_store = req_valid && (req_op >= OP_SB) && (req_op <= OP_SW);
  assign is_lui   = req_valid && (req_op == OP_LUI);
  assign sz_byte  = (req_op == OP_LB) || (req_op == OP_LBU) || (req_op == OP_SB);
  assign sz_half  = (req_op == OP_LH) || (req_op == OP_LHU) || (req_op == OP_SH);
  assign sz_word  = (req_op == OP_LW) || (req_op == OP_SW);
  assign bad_align = (sz_word && ea[1:0] != 2'b00) || (sz_half && ea[0]);

  always_comb begin
    lanes = 4'b0000;
    wrep  = req_wdata;
    if (sz_byte) begin
      lanes = 4'b1000 >> ea[1:0];
      wrep  = {4{req_wdata[7:0]}};
    end else if (sz_half) begin
      lanes = ea[1] ? 4'b0011 : 4'b1100;
      wrep  = {2{req_wdata[15:0]}};
    end else if (sz_word) begin
      lanes = 4'b1111;
    end
  end

  logic [3:0]  s_op;
  logic [1:0]  s_lane;
  logic        s_lui;
  logic [15:0] s_imm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr  <= '0;
      mem_rd    <= 1'b0;
      mem_we    <= '0;
      mem_wdata <= '0;
      misalign  <= 1'b0;
      s_op      <= '0;
      s_lane    <= '0;
      s_lui     <= 1'b0;
      s_imm     <= '0;
    end else begin
      mem_rd   <= is_load && !bad_align;
      mem_we   <= (is_store && !bad_align) ? lanes : 4'b0000;
      misalign <= (is_load || is_store) && bad_align;
      s_lui    <= is_lui;
      if (req_valid) begin
        mem_addr <= {ea[31:2], 2'b00};
        s_op     <= req_op;
        s_lane   <= ea[1:0];
        s_imm    <= req_offset;
      end
      if (is_store) mem_wdata <= wrep;
    end
  end

  logic [7:0]  pick_b;
  logic [15:0] pick_h;
  logic [31:0] ext;

  assign pick_b = mem_rdata[8*(3-s_lane) +: 8];
  assign pick_h = s_lane[1] ? mem_rdata[15:0] : mem_rdata[31:16];

  always_comb begin
    case (s_op)
      OP_LB:   ext = {{24{pick_b[7]}}, pick_b};
      OP_LBU:  ext = {24'h0, pick_b};
      OP_LH:   ext = {{16{pick_h[15]}}, pick_h};
      OP_LHU:  ext = {16'h0, pick_h};
      default: ext = mem_rdata;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= mem_rd || s_lui;
      if (s_lui)       rsp_data <= {s_imm, 16'h0000};
      else if (mem_rd) rsp_data <= ext;
    end
  end

  // R7
  mis_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> (mem_we == 4'b0000 && !mem_rd));

  // R2
  lane_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we != 4'b0000) |-> ($countones(mem_we) == 1 || mem_we == 4'b1100 ||
                             mem_we == 4'b0011 || mem_we == 4'b1111));

  // R8
  rd_no_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (mem_we == 4'b0000));

  // R6
  rd_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> rsp_valid);

  // R9
  lui_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !$past(mem_rd)) |-> (rsp_data[15:0] == 16'h0000));
endmodule

// File: tb/sim_lsu_lane_align.sv
module sim_lsu_lane_align;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [3:0]  req_op = 4'd15;
  logic [31:0] req_base = '0;
  logic [15:0] req_offset = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] mem_rdata;
  logic [31:0] mem_addr;
  logic        mem_rd;
  logic [3:0]  mem_we;
  logic [31:0] mem_wdata;
  logic        misalign;
  logic        rsp_valid;
  logic [31:0] rsp_data;

  always #10 clk = ~clk;

  lsu_lane_align u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_base(req_base), .req_offset(req_offset), .req_wdata(req_wdata),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .misalign(misalign), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  logic [31:0] mem [16];
  initial for (int i = 0; i < 16; i++) mem[i] = 32'h8A7FC035 + i * 32'h1D3B5977;
  assign mem_rdata = mem[mem_addr[5:2]];
  always @(posedge clk)
    for (int i = 0; i < 4; i++)
      if (mem_we[i]) mem[mem_addr[5:2]][8*i +: 8] <= mem_wdata[8*i +: 8];

  int checks = 0;
  int failures = 0;

  // behavioural reference model
  logic [31:0] e_addr, e_wd, e_rsp;
  logic [3:0]  e_we;
  logic        e_rd, e_mis, e_rv;
  string       e_tag;
  int          p_op, p_lane;
  logic        p_lui;
  logic [15:0] p_imm;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_addr = 0; e_wd = 0; e_rsp = 0; e_we = 0; e_rd = 0; e_mis = 0; e_rv = 0;
      p_op = 0; p_lane = 0; p_lui = 0; p_imm = 0; e_tag = "R10";
    end else begin
      int w, v;
      logic [31:0] a;
      int op;
      e_rv = e_rd || p_lui;
      if (p_lui) begin
        e_rsp = {p_imm, 16'h0}; e_tag = "R9";
      end else if (e_rd) begin
        w = mem[e_addr[5:2]];
        if (p_op == 0 || p_op == 3) begin
          v = (w >>> (24 - 8 * p_lane)) & 255;
          if (p_op == 0 && v >= 128) v = v - 256;
          e_tag = (p_op == 0) ? "R4" : "R5";
        end else if (p_op == 1 || p_op == 4) begin
          v = (w >>> (16 - 8 * p_lane)) & 65535;
          if (p_op == 1 && v >= 32768) v = v - 65536;
          e_tag = (p_op == 1) ? "R4" : "R5";
        end else begin
          v = w; e_tag = "R6";
        end
        e_rsp = v;
      end
      op = req_op;
      a = req_base + 32'(signed'(req_offset));
      p_lui = req_valid && op == 8;
      e_rd = 0; e_we = 0; e_mis = 0;
      if (req_valid) begin
        p_op = op; p_lane = a % 4; p_imm = req_offset;
        e_addr = a - (a % 4);
        if (op <= 7) begin
          int sz;
          sz = (op == 0 || op == 3 || op == 5) ? 1 : (op == 1 || op == 4 || op == 6) ? 2 : 4;
          if (a % sz != 0) e_mis = 1;
          else if (op <= 4) e_rd = 1;
          else begin
            if (sz == 1) begin
              e_we = 4'(8 >> p_lane);
              e_wd = {4{req_wdata[7:0]}};
            end else if (sz == 2) begin
              e_we = (p_lane == 2) ? 4'b0011 : 4'b1100;
              e_wd = {2{req_wdata[15:0]}};
            end else begin
              e_we = 4'b1111; e_wd = req_wdata;
            end
          end
        end
      end
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      chk(mem_addr == 0 && mem_we == 0 && mem_wdata == 0 && !mem_rd && !misalign && !rsp_valid && rsp_data == 0,
          "R10", {mem_we, 3'b0, mem_rd, 3'b0, misalign, 3'b0, rsp_valid, rsp_data[15:0]}, 0);
    end else begin
      chk(mem_rd == e_rd, "R8", 32'(mem_rd), 32'(e_rd));
      chk(mem_we == e_we, "R2", 32'(mem_we), 32'(e_we));
      chk(misalign == e_mis, "R7", 32'(misalign), 32'(e_mis));
      chk(rsp_valid == e_rv, "R6", 32'(rsp_valid), 32'(e_rv));
      if (e_rd || e_we != 0) chk(mem_addr == e_addr, "R1", mem_addr, e_addr);
      if (e_we != 0) chk(mem_wdata == e_wd, "R3", mem_wdata, e_wd);
      if (e_rv) chk(rsp_data == e_rsp, e_tag, rsp_data, e_rsp);
    end
  end

  task automatic put(input int op, input logic [31:0] base, input logic [15:0] off, input logic [31:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_op = 4'(op); req_base = base; req_offset = off; req_wdata = wd;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0; req_op = 4'd15;
    end
  endtask

  bit done = 0;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    // stores: every byte lane, both halves, whole word, base 0 and offset 0
    for (int k = 0; k < 4; k++) put(5, 32'h100, 16'(k), 32'hA5C3_1E00 + k);
    put(6, 32'h0, 16'h0008, 32'h1234_F00D);
    put(6, 32'h0, 16'h000A, 32'h9876_8001);
    put(7, 32'h0000_0030, 16'h0000, 32'hDEAD_BEEF);
    idle(2);
    // loads of each kind at every aligned offset
    for (int k = 0; k < 4; k++) begin
      put(0, 32'h100, 16'(k), 0);
      put(3, 32'h100, 16'(k), 0);
    end
    put(1, 32'h0, 16'h0008, 0); put(4, 32'h0, 16'h000A, 0);
    put(1, 32'h0, 16'h000A, 0); put(4, 32'h0, 16'h0008, 0);
    put(2, 32'h0000_0030, 16'h0000, 0);
    // negative offset
    put(2, 32'h0000_0044, 16'hFFFC, 0);
    put(0, 32'h0000_0048, 16'hFFF9, 0);
    // misaligned word and halfword, both directions
    put(7, 32'h40, 16'h0001, 32'hFFFF_FFFF);
    put(2, 32'h40, 16'h0002, 0);
    put(6, 32'h40, 16'h0003, 32'hFFFF_FFFF);
    put(1, 32'h40, 16'h0001, 0);
    // load-upper-immediate and unused codes
    put(8, 32'h0, 16'h1234, 0);
    put(8, 32'hFFFF_FFFF, 16'hABCD, 0);
    put(9, 32'h0, 16'h0, 32'hFFFF_FFFF);
    put(15, 32'h0, 16'h0, 32'hFFFF_FFFF);
    idle(3);
    for (int n = 0; n < 600; n++) begin
      if ($urandom % 4 == 0) idle(1);
      else put($urandom % 11, $urandom, 16'($urandom), $urandom);
    end
    idle(4);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule